// File: doc/BRIEF.md
# Paging Address Translator with Associative Buffer

The block turns a logical address from a processor into a physical address. The upper bits of the address form a virtual page number and the low bits are the byte offset within the page. A small, fully associative translation buffer holds recent page-to-frame mappings and compares the page number against every entry at once. On a hit, the frame number comes from the buffer and the translation finishes in one cycle with no memory traffic.

On a miss, the block reads one page-table entry from a single-level table in memory. The entry sits at the table base plus four times the page number. The entry goes into the buffer and the translation completes. Three conditions raise a fault:

- the page number lies beyond the table length;
- the entry is not valid;
- a write targets a read-only page.

The buffer also keeps a per-page dirty flag, which is set when a write is translated.

A processor drives `cpu_req` and holds the address until `cpu_ready` pulses. The page-table base and length are supplied as plain inputs. Pulsing `flush` empties the buffer in one cycle, for example after a table change.

Top module: `paging_xlate`

## Requirements
- R1: A translation with no fault returns a physical address whose bits above PAGE_BITS are the frame number (page-table entry bits [ADDR_W-1:PAGE_BITS]) and whose low PAGE_BITS bits equal the request's offset.
- R2: A request whose page number is held in the buffer completes with `cpu_ready` high for exactly one cycle, on the first clock edge after the request is seen, and issues no memory read.
- R3: On a buffer miss, exactly one one-cycle `mem_req` is issued at address `pt_base + 4*page`. `cpu_ready` rises on the edge after the cycle in which `mem_rvalid` is high.
- R4: A page number greater than or equal to `pt_len` completes in one cycle with `cpu_fault` = 1 and no memory read. A page number equal to `pt_len-1` translates normally.
- R5: An entry with bit 0 (valid) clear gives `cpu_fault` = 2 and is not loaded, so a repeat request for that page reads memory again.
- R6: Entry bit 1 marks the page read-only. A write to such a page gives `cpu_fault` = 3, whether the page hits or misses. A read of such a page succeeds, and a page loaded on a faulting write miss is held in the buffer.
- R7: Entry bit 2 is the dirty flag. On a completed translation with no fault, `cpu_dirty` reports the page's flag after the access. A translated write sets the flag in the buffer, so later hits on that page report 1.
- R8: Misses fill empty buffer entries first, lowest index first. Once every entry is valid, fills replace entries in round-robin order starting at entry 0.
- R9: A one-cycle `flush` invalidates every entry, so the next request for any page misses.
- R10: After reset, `cpu_ready` and `mem_req` are low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all buffer entries |
| pt_base | input | ADDR_W | Byte address of the page table |
| pt_len | input | ADDR_W-PAGE_BITS+1 | Number of entries in the page table |
| cpu_req | input | 1 | Translation request, held until `cpu_ready` |
| cpu_addr | input | ADDR_W | Logical address |
| cpu_write | input | 1 | Request is a write |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_paddr | output | ADDR_W | Physical address (zero on fault) |
| cpu_fault | output | 2 | 0 none, 1 length, 2 invalid, 3 protection |
| cpu_dirty | output | 1 | Dirty flag of the page after this access |
| mem_req | output | 1 | One-cycle page-table read request |
| mem_addr | output | ADDR_W | Page-table entry address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | ADDR_W | Page-table entry |

## Verification
The bench builds the block with a four-entry buffer. At that size the buffer fills after four misses, so wrap-around of the round-robin pointer and eviction of specific pages are reached within a short table of accesses. The 32-bit address and 4 KiB pages keep their default values. The table length is set to 64 so that the length fault and its last legal page can both be reached.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_LEN  = 2'd1,
    FLT_INV  = 2'd2,
    FLT_PROT = 2'd3
  } fault_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_WAIT = 1'b1
  } xstate_e;

  localparam int PTE_V_BIT  = 0;
  localparam int PTE_RO_BIT = 1;
  localparam int PTE_D_BIT  = 2;
endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [PFN_W-1:0]   hit_pfn,
  output logic               hit_ro,
  output logic               hit_dirty,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PFN_W-1:0]   fill_pfn,
  input  logic               fill_ro,
  input  logic               fill_dirty,
  input  logic               mark_en,
  input  logic [IDX_W-1:0]   mark_idx,
  output logic [ENTRIES-1:0] valid_vec
);
  logic [VPN_W-1:0] tag_q [ENTRIES];
  logic [PFN_W-1:0] pfn_q [ENTRIES];
  logic [ENTRIES-1:0] ro_q;
  logic [ENTRIES-1:0] dirty_q;
  logic [ENTRIES-1:0] match;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = valid_vec[g] && (tag_q[g] == lk_vpn);
    end
  endgenerate

  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit       = |match;
  assign hit_pfn   = pfn_q[hit_idx];
  assign hit_ro    = ro_q[hit_idx];
  assign hit_dirty = dirty_q[hit_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_vec <= '0;
    end else if (flush) begin
      valid_vec <= '0;
    end else if (fill_en) begin
      valid_vec[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]   <= fill_vpn;
      pfn_q[fill_idx]   <= fill_pfn;
      ro_q[fill_idx]    <= fill_ro;
      dirty_q[fill_idx] <= fill_dirty;
    end else if (mark_en) begin
      dirty_q[mark_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/xlate_victim.sv
module xlate_victim #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               advance,
  output logic [IDX_W-1:0]   victim
);
  logic [IDX_W-1:0] rr_q;
  logic             found;

  always_comb begin
    victim = rr_q;
    found  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!found && !valid_vec[i]) begin
        victim = IDX_W'(i);
        found  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (advance && (&valid_vec)) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end
endmodule

// File: rtl/paging_xlate.sv
module paging_xlate
  import xlate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic [ADDR_W-1:0]             pt_base,
  input  logic [ADDR_W-PAGE_BITS:0]     pt_len,
  input  logic                          cpu_req,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic                          cpu_write,
  output logic                          cpu_ready,
  output logic [ADDR_W-1:0]             cpu_paddr,
  output logic [1:0]                    cpu_fault,
  output logic                          cpu_dirty,
  output logic                          mem_req,
  output logic [ADDR_W-1:0]             mem_addr,
  input  logic                          mem_rvalid,
  input  logic [ADDR_W-1:0]             mem_rdata
);
  localparam int VPN_W = ADDR_W - PAGE_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  xstate_e state;
  fault_e  fault_q;
  logic    busy;

  logic [VPN_W-1:0]     req_vpn;
  logic [PAGE_BITS-1:0] req_off;
  logic [VPN_W-1:0]     lat_vpn;
  logic [PAGE_BITS-1:0] lat_off;
  logic                 lat_wr;

  logic               hit, hit_ro, hit_dirty;
  logic [IDX_W-1:0]   hit_idx, victim;
  logic [VPN_W-1:0]   hit_pfn;
  logic [ENTRIES-1:0] valid_vec;
  logic               accept, len_bad, fill_en, mark_en, fill_dirty;

  logic [VPN_W-1:0] pte_pfn;
  logic             pte_v, pte_ro, pte_d;
  logic             unused_pte;

  assign busy    = (state == S_WAIT);
  assign req_vpn = cpu_addr[ADDR_W-1:PAGE_BITS];
  assign req_off = cpu_addr[PAGE_BITS-1:0];
  assign accept  = cpu_req && !cpu_ready && !busy;
  assign len_bad = ({1'b0, req_vpn} >= pt_len);

  assign pte_pfn    = mem_rdata[ADDR_W-1:PAGE_BITS];
  assign pte_v      = mem_rdata[PTE_V_BIT];
  assign pte_ro     = mem_rdata[PTE_RO_BIT];
  assign pte_d      = mem_rdata[PTE_D_BIT];
  assign unused_pte = ^mem_rdata[PAGE_BITS-1:PTE_D_BIT+1];

  assign fill_en    = busy && mem_rvalid && pte_v;
  assign fill_dirty = pte_d || (lat_wr && !pte_ro);
  assign mark_en    = accept && !len_bad && hit && cpu_write && !hit_ro && !hit_dirty;
  assign cpu_fault  = fault_q;

  xlate_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(VPN_W), .IDX_W(IDX_W)) u_tlb (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_vpn(req_vpn), .hit(hit), .hit_idx(hit_idx), .hit_pfn(hit_pfn),
    .hit_ro(hit_ro), .hit_dirty(hit_dirty),
    .fill_en(fill_en), .fill_idx(victim), .fill_vpn(lat_vpn), .fill_pfn(pte_pfn),
    .fill_ro(pte_ro), .fill_dirty(fill_dirty),
    .mark_en(mark_en), .mark_idx(hit_idx), .valid_vec(valid_vec)
  );

  xlate_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .valid_vec(valid_vec), .advance(fill_en), .victim(victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cpu_ready <= 1'b0;
      cpu_paddr <= '0;
      fault_q   <= FLT_NONE;
      cpu_dirty <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      lat_vpn   <= '0;
      lat_off   <= '0;
      lat_wr    <= 1'b0;
    end else begin
      cpu_ready <= 1'b0;
      mem_req   <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            lat_vpn <= req_vpn;
            lat_off <= req_off;
            lat_wr  <= cpu_write;
            if (len_bad) begin
              cpu_ready <= 1'b1;
              fault_q   <= FLT_LEN;
              cpu_paddr <= '0;
              cpu_dirty <= 1'b0;
            end else if (hit) begin
              cpu_ready <= 1'b1;
              if (cpu_write && hit_ro) begin
                fault_q   <= FLT_PROT;
                cpu_paddr <= '0;
                cpu_dirty <= hit_dirty;
              end else begin
                fault_q   <= FLT_NONE;
                cpu_paddr <= {hit_pfn, req_off};
                cpu_dirty <= hit_dirty || cpu_write;
              end
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= pt_base + {{(ADDR_W-VPN_W-2){1'b0}}, req_vpn, 2'b00};
              state    <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (mem_rvalid) begin
            state     <= S_IDLE;
            cpu_ready <= 1'b1;
            if (!pte_v) begin
              fault_q   <= FLT_INV;
              cpu_paddr <= '0;
              cpu_dirty <= 1'b0;
            end else if (lat_wr && pte_ro) begin
              fault_q   <= FLT_PROT;
              cpu_paddr <= '0;
              cpu_dirty <= pte_d;
            end else begin
              fault_q   <= FLT_NONE;
              cpu_paddr <= {pte_pfn, lat_off};
              cpu_dirty <= fill_dirty;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/paging_xlate_chk.sv
module paging_xlate_chk #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      flush,
  input logic                      cpu_req,
  input logic [ADDR_W-PAGE_BITS-1:0] vpn,
  input logic [ADDR_W-PAGE_BITS:0] pt_len,
  input logic                      cpu_ready,
  input logic [1:0]                cpu_fault,
  input logic                      mem_req,
  input logic                      mem_rvalid,
  input logic                      busy,
  input logic [ENTRIES-1:0]        valid_vec
);
  // R2
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  // R3
  mem_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R3
  fill_done_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && mem_rvalid) |=> cpu_ready);

  // R4
  len_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !cpu_ready && !busy && ({1'b0, vpn} >= pt_len))
      |=> (cpu_ready && cpu_fault == 2'd1 && !mem_req));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_vec == '0));
endmodule

bind paging_xlate paging_xlate_chk #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ENTRIES(ENTRIES)
) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .cpu_req(cpu_req),
  .vpn(cpu_addr[ADDR_W-1:PAGE_BITS]), .pt_len(pt_len),
  .cpu_ready(cpu_ready), .cpu_fault(cpu_fault), .mem_req(mem_req),
  .mem_rvalid(mem_rvalid), .busy(busy), .valid_vec(valid_vec)
);

// File: tb/paging_xlate_bench.sv
`timescale 1ns/1ps
module paging_xlate_bench;
  localparam int ADDR_W = 32;
  localparam int PB     = 12;
  localparam int NENT   = 4;
  localparam logic [31:0] PTBR = 32'h0010_0000;
  localparam logic [20:0] PTLEN = 21'd64;

  // {vpn[7:0], write, expect_miss, expect_dirty}
  localparam int NVEC = 17;
  localparam logic [10:0] VEC [NVEC] = '{
    {8'd1,  1'b0, 1'b1, 1'b0}, {8'd1,  1'b0, 1'b0, 1'b0},
    {8'd2,  1'b1, 1'b1, 1'b1}, {8'd2,  1'b0, 1'b0, 1'b1},
    {8'd3,  1'b0, 1'b1, 1'b0}, {8'd3,  1'b1, 1'b0, 1'b0},
    {8'd5,  1'b0, 1'b1, 1'b0}, {8'd5,  1'b0, 1'b1, 1'b0},
    {8'd4,  1'b0, 1'b1, 1'b1}, {8'd6,  1'b0, 1'b1, 1'b0},
    {8'd2,  1'b0, 1'b0, 1'b1}, {8'd1,  1'b0, 1'b1, 1'b0},
    {8'd2,  1'b0, 1'b1, 1'b0}, {8'd4,  1'b1, 1'b0, 1'b1},
    {8'd70, 1'b0, 1'b0, 1'b0}, {8'd8,  1'b1, 1'b1, 1'b0},
    {8'd8,  1'b0, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic cpu_req = 1'b0;
  logic cpu_write = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic cpu_ready, cpu_dirty, mem_req;
  logic [31:0] cpu_paddr, mem_addr;
  logic [1:0] cpu_fault;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] last_addr = '0;
  int rd_count = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  paging_xlate #(.ADDR_W(ADDR_W), .PAGE_BITS(PB), .ENTRIES(NENT)) u_paging_xlate (
    .clk(clk), .rst(rst), .flush(flush), .pt_base(PTBR), .pt_len(PTLEN),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_write(cpu_write),
    .cpu_ready(cpu_ready), .cpu_paddr(cpu_paddr), .cpu_fault(cpu_fault),
    .cpu_dirty(cpu_dirty), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [19:0] frame_of(input logic [19:0] vpn);
    return vpn ^ 20'h5A5C3;
  endfunction

  function automatic logic pv(input int vpn);   return (vpn % 7) != 5;  endfunction
  function automatic logic pro(input int vpn);  return (vpn % 5) == 3;  endfunction
  function automatic logic pd(input int vpn);   return (vpn % 11) == 4; endfunction

  function automatic logic [31:0] pte_of(input logic [19:0] vpn);
    return {frame_of(vpn), 9'd0, pd(int'(vpn)), pro(int'(vpn)), pv(int'(vpn))};
  endfunction

  function automatic logic [1:0] exp_fault(input int vpn, input logic wr);
    if (vpn >= int'(PTLEN)) return 2'd1;
    if (!pv(vpn)) return 2'd2;
    if (wr && pro(vpn)) return 2'd3;
    return 2'd0;
  endfunction

  // memory model: answers one cycle after a request
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= pte_of(20'((mem_addr - PTBR) >> 2));
      rd_count   <= rd_count + 1;
      last_addr  <= mem_addr;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [19:0] vpn, input logic [11:0] off, input logic wr,
                        output int cyc, output int nrd, output logic [31:0] pa,
                        output logic [1:0] flt, output logic dy);
    int rd0;
    rd0 = rd_count;
    cyc = 0;
    cpu_addr  = {vpn, off};
    cpu_write = wr;
    cpu_req   = 1'b1;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 20);
    pa  = cpu_paddr;
    flt = cpu_fault;
    dy  = cpu_dirty;
    nrd = rd_count - rd0;
    cpu_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_one(input string tag, input int vpn, input logic [11:0] off,
                         input logic wr, input logic miss, input logic dexp);
    int cyc, nrd;
    logic [31:0] pa;
    logic [1:0] flt, ef;
    access(20'(vpn), off, wr, cyc, nrd, pa, flt, dy_tmp);
    ef = exp_fault(vpn, wr);
    chk({tag, " fault R4 R5 R6"}, {30'd0, flt}, {30'd0, ef});
    chk({tag, " latency R2 R3"}, cyc, miss ? 3 : 1);
    chk({tag, " reads R2 R3 R8"}, nrd, miss ? 1 : 0);
    if (miss) chk({tag, " pte address R3"}, last_addr, PTBR + 32'(vpn * 4));
    if (ef == 2'd0) begin
      chk({tag, " paddr R1"}, pa, {frame_of(20'(vpn)), off});
      chk({tag, " dirty R7"}, {31'd0, dy_tmp}, {31'd0, dexp});
    end
  endtask

  logic dy_tmp;

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("reset ready R10", {31'd0, cpu_ready}, 32'd0);
    chk("reset memreq R10", {31'd0, mem_req}, 32'd0);
    chk("reset reads R10", rd_count, 0);

    // table walk: hits, misses, faults, replacement (R8)
    for (int i = 0; i < NVEC; i++) begin
      run_one($sformatf("vec%0d", i), int'(VEC[i][10:3]), 12'((i * 12'h111) & 12'hFFF),
              VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R4 boundary: last legal page and first illegal page
    run_one("len_last R4", 63, 12'hABC, 1'b0, 1'b1, 1'b0);
    run_one("len_first R4", 64, 12'h001, 1'b0, 1'b0, 1'b0);

    // R9 flush: page 8 is held; after flush it must miss
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    run_one("after_flush R9", 8, 12'h777, 1'b0, 1'b1, 1'b0);
    run_one("refill_hit R9", 8, 12'h778, 1'b0, 1'b0, 1'b0);

    // R6 read of read-only page at a fresh vpn, then write hit faults
    run_one("ro_read R6", 13, 12'h010, 1'b0, 1'b1, 1'b0);
    run_one("ro_write R6", 13, 12'h020, 1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule